// File: doc/BRIEF.md
# FIFO-Level Transfer Arbiter

This block sits in the memory clock domain of a frame-buffer datapath. It watches how full the input FIFO is (filled by the camera side) and how full the output FIFO is (drained by the display side). From these levels it decides when the memory controller should move a burst from the input FIFO into memory, and when it should move a burst from memory into the output FIFO. It does this only while the controller reports that it is ready. Each decision comes out as a one-cycle start pulse.

The thresholds are parameters. The write threshold sits below full and the read threshold sits above empty. Transfers therefore start early, so the fast memory-side transfer completes before the slow producer fills its FIFO or the slow consumer empties its FIFO. The integrator must pick the thresholds with enough margin for one full transfer.

The controller has four states:
- `ST_IDLE` evaluates the levels.
- `ST_ISSUE_WR` and `ST_ISSUE_RD` each drive their pulse for exactly one cycle.
- `ST_WAIT_BUSY` holds until the controller has shown a busy period.

The transitions are:
- IDLE→ISSUE_WR when ready and the write level is met.
- IDLE→ISSUE_RD when ready, the write level is not met and the read level is met.
- ISSUE_WR→WAIT_BUSY and ISSUE_RD→WAIT_BUSY unconditionally.
- WAIT_BUSY→IDLE once ready has been seen low (from the issue cycle onward) and is now high.

Top module: `xfer_arb`

## Requirements
- R1: While reset is asserted and right after it, both `start_wr` and `start_rd` are 0 and the machine is idle.
- R2: No start pulse is produced while `ctrl_ready` is 0, whatever the FIFO levels are.
- R3: When idle with `ctrl_ready`=1 and `in_level >= WR_THRESH` at a rising clock edge, `start_wr` is 1 during the following cycle. `in_level = WR_THRESH-1` produces no pulse.
- R4: When idle with `ctrl_ready`=1, the write condition false and `out_level < RD_THRESH` at a rising clock edge, `start_rd` is 1 during the following cycle. `out_level = RD_THRESH` produces no pulse.
- R5: If both level conditions hold in the same idle cycle, `start_wr` is issued and `start_rd` is not.
- R6: After any start pulse, no further pulse occurs until `ctrl_ready` has been 0 for at least one cycle and has then returned to 1, even if ready stays high and the levels keep demanding service.
- R7: Each start pulse lasts exactly one cycle, and `start_wr` and `start_rd` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_ready | input | 1 | Memory controller can accept a command |
| in_level | input | LVL_W | Word count in the input FIFO |
| out_level | input | LVL_W | Word count in the output FIFO |
| start_wr | output | 1 | One-cycle pulse: drain input FIFO into memory |
| start_rd | output | 1 | One-cycle pulse: refill output FIFO from memory |

## Verification
The bench drives the levels exactly one below and at each threshold. A comparison that is off by one at either edge would emit or miss a pulse there. It raises both demands together while the controller is not ready, then releases ready. A design that ignored ready would pulse early, and one with swapped priority would issue a read first. After some pulses it holds ready high for several cycles with demands still pending. This catches a design that leaves the wait state without seeing a busy period, because such a design reissues the command repeatedly. Every pulse is also checked for width and exclusivity against a queue of expected commands.

// File: rtl/xfer_arb_pkg.sv
package xfer_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ISSUE_WR  = 2'd1,
        ST_ISSUE_RD  = 2'd2,
        ST_WAIT_BUSY = 2'd3
    } arb_state_t;

endpackage

// File: rtl/xfer_level_cmp.sv
module xfer_level_cmp #(
    parameter int LVL_W       = 9,
    parameter int THRESH      = 256,
    parameter bit AT_OR_ABOVE = 1'b1
) (
    input  logic [LVL_W-1:0] level,
    output logic             hit
);

    localparam logic [LVL_W-1:0] THR = LVL_W'(THRESH);

    generate
        if (AT_OR_ABOVE) begin : g_ge
            // fill side: trigger once enough words are waiting
            assign hit = (level >= THR);
        end else begin : g_lt
            // drain side: trigger once the reserve runs low
            assign hit = (level < THR);
        end
    endgenerate

endmodule

// File: rtl/xfer_busy_track.sv
module xfer_busy_track (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic ready,
    output logic done
);

    logic seen_low;

    // arm restarts observation in the issue cycle; any low ready afterwards is remembered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_low <= 1'b0;
        end else if (arm) begin
            seen_low <= ~ready;
        end else if (!ready) begin
            seen_low <= 1'b1;
        end
    end

    assign done = seen_low & ready;

endmodule

// File: rtl/xfer_arb.sv
module xfer_arb
    import xfer_arb_pkg::*;
#(
    parameter int LVL_W     = 9,
    parameter int WR_THRESH = 448,
    parameter int RD_THRESH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_ready,
    input  logic [LVL_W-1:0] in_level,
    input  logic [LVL_W-1:0] out_level,
    output logic             start_wr,
    output logic             start_rd
);

    arb_state_t state, state_nx;
    logic       wr_hit, rd_hit, busy_done, arm;

    xfer_level_cmp #(
        .LVL_W      (LVL_W),
        .THRESH     (WR_THRESH),
        .AT_OR_ABOVE(1'b1)
    ) u_wr_cmp (
        .level(in_level),
        .hit  (wr_hit)
    );

    xfer_level_cmp #(
        .LVL_W      (LVL_W),
        .THRESH     (RD_THRESH),
        .AT_OR_ABOVE(1'b0)
    ) u_rd_cmp (
        .level(out_level),
        .hit  (rd_hit)
    );

    assign arm = (state == ST_ISSUE_WR) || (state == ST_ISSUE_RD);

    xfer_busy_track u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (arm),
        .ready(ctrl_ready),
        .done (busy_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ctrl_ready && wr_hit)      state_nx = ST_ISSUE_WR;  // camera side first
                else if (ctrl_ready && rd_hit) state_nx = ST_ISSUE_RD;
            end
            ST_ISSUE_WR:  state_nx = ST_WAIT_BUSY;
            ST_ISSUE_RD:  state_nx = ST_WAIT_BUSY;
            ST_WAIT_BUSY: if (busy_done) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        start_wr = 1'b0;
        start_rd = 1'b0;
        unique case (state)
            ST_ISSUE_WR: start_wr = 1'b1;
            ST_ISSUE_RD: start_rd = 1'b1;
            default: ;
        endcase
    end

    // R7: never both, and every pulse is a single cycle
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_wr && start_rd));
    a_r7_single_wr: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> !start_wr);
    a_r7_single_rd: assert property (@(posedge clk) disable iff (!rst_n)
        start_rd |=> !start_rd);
    // R2: an idle machine with ready low emits nothing next cycle
    a_r2_need_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !ctrl_ready) |=> !(start_wr || start_rd));
    // R5: write demand wins when ready
    a_r5_wr_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ctrl_ready && wr_hit) |=> (start_wr && !start_rd));
    // R6: waiting with ready low never returns straight to idle
    a_r6_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_BUSY && !ctrl_ready) |=> (state == ST_WAIT_BUSY));
    // R6: a pulse is followed by the wait state
    a_r6_enter_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr || start_rd) |=> (state == ST_WAIT_BUSY));

endmodule

// File: tb/test_xfer_arb.sv
module test_xfer_arb;

    localparam int CLK_PERIOD = 10;
    localparam int LVL_W      = 6;
    localparam int WR_T       = 40;
    localparam int RD_T       = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctrl_ready = 1'b0;
    logic [LVL_W-1:0] in_level = '0;
    logic [LVL_W-1:0] out_level = 6'd20;
    logic             start_wr, start_rd;

    int    n_vec  = 0;
    int    n_fail = 0;
    int    cycles = 0;
    logic  exp_q[$];
    string tag_q[$];
    logic  prev_pulse = 1'b0;
    bit    done = 1'b0;

    xfer_arb #(.LVL_W(LVL_W), .WR_THRESH(WR_T), .RD_THRESH(RD_T)) i_xfer_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_ready(ctrl_ready),
        .in_level  (in_level),
        .out_level (out_level),
        .start_wr  (start_wr),
        .start_rd  (start_rd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    // monitor: every pulse must match the head of the expected queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_wr && start_rd) begin
                n_fail++;
                $display("FAIL R7 both pulses: actual=11 expected=one-hot");
            end
            if (prev_pulse && (start_wr || start_rd)) begin
                n_fail++;
                $display("FAIL R7 pulse wider than one cycle: actual=2 expected=1");
            end
            if (start_wr || start_rd) begin
                n_vec++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R6 unexpected pulse: actual wr=%0b rd=%0b expected none",
                             start_wr, start_rd);
                end else begin
                    logic  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (start_wr != e) begin
                        n_fail++;
                        $display("FAIL %s command kind: actual wr=%0b expected wr=%0b",
                                 t, start_wr, e);
                    end
                end
            end
            prev_pulse <= start_wr || start_rd;
        end
    end

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            n_vec++;
            if (start_wr || start_rd) begin
                n_fail++;
                $display("FAIL %s: actual wr=%0b rd=%0b expected none", tag, start_wr, start_rd);
            end
        end
    endtask

    // driver: levels already set, ready high, machine idle at this negedge
    task automatic issue(input logic is_wr, input string tag, input int hold_hi, input int busy);
        exp_q.push_back(is_wr);
        tag_q.push_back(tag);
        @(negedge clk);
        n_vec++;
        if ((is_wr ? start_wr : start_rd) !== 1'b1) begin
            n_fail++;
            $display("FAIL %s pulse timing: actual wr=%0b rd=%0b expected %s",
                     tag, start_wr, start_rd, is_wr ? "wr" : "rd");
        end
        if (hold_hi > 0) quiet(hold_hi, "R6 ready never dropped");
        ctrl_ready = 1'b0;
        repeat (busy) @(negedge clk);
        ctrl_ready = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            n_vec++;
            if (start_wr || start_rd) begin
                n_fail++;
                $display("FAIL R1 reset: actual wr=%0b rd=%0b expected 00", start_wr, start_rd);
            end
        end
        rst_n = 1'b1;
        quiet(2, "R1 after reset");

        // threshold boundaries
        ctrl_ready = 1'b1;
        in_level   = 6'(WR_T - 1);
        out_level  = 6'(RD_T);
        quiet(4, "R3/R4 boundary");
        in_level = 6'(WR_T);
        issue(1'b1, "R3", 0, 2);
        in_level = 6'd10;
        out_level = 6'(RD_T - 1);
        issue(1'b0, "R4", 0, 3);
        out_level = 6'd20;
        quiet(3, "R4 released");

        // ready low blocks commands
        ctrl_ready = 1'b0;
        in_level   = 6'd50;
        out_level  = 6'd2;
        quiet(4, "R2");
        ctrl_ready = 1'b1;
        issue(1'b1, "R5", 3, 2);
        issue(1'b1, "R5", 0, 1);
        in_level = 6'd5;
        issue(1'b0, "R4", 4, 1);
        out_level = 6'd30;
        in_level  = 6'd63;
        issue(1'b1, "R6", 5, 4);
        in_level = 6'd0;
        quiet(4, "R7 idle");

        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R3 missing pulses: actual=%0d pending expected=0", exp_q.size());
        end
        done = 1'b1;
        summary();
    end

endmodule